// File: doc/BRIEF.md
# Channel Startup Timer and Fault Supervisor

This block supervises one switching-regulator channel, counting in switching cycles rather than clock cycles: every high `tick_i` marks the end of one switching period. Once the channel is enabled it raises a current-limit code in equal steps from zero to full scale. It also holds power-good low for a long settling window, and it keeps the deep undervoltage check disarmed until the output has had time to reach regulation.

Comparator flags from the analog side feed a fault latch. An overvoltage trips the latch at any time while the channel is enabled and also requests that the low-side switch be held on. A deep undervoltage trips the latch only once that check is armed. The shallow power-good flag and the thermal flag act at once but latch nothing. The peer channel's latch output enters on `peer_fault_i`, so a fault on either channel stops both. Every timer restarts from zero whenever the channel is not running. Dropping the enable is the only way to clear the latch.

Top module: `chan_start_supervisor`

## Requirements
- R1: While `en_i` is low, `ilim_code_o` is 0 and `pg_o` is 0; on the first clock edge with `en_i` low, `fault_o` and `force_ls_o` clear to 0.
- R2: While running, `ilim_code_o` equals the number of counted ticks divided by STEP_LEN (RAMP_CYCLES/RAMP_STEPS, truncated). A tick counts only on an edge where `tick_i` is high.
- R3: `ilim_code_o` saturates at RAMP_STEPS (full scale) and holds there while running.
- R4: `pg_o` stays 0 until PG_CYCLES ticks have been counted since the run began, and is 1 from then on while running with `pg_low_i` low.
- R5: `pg_low_i` high forces `pg_o` to 0 in the same cycle without latching; `pg_o` returns when the flag drops.
- R6: `uv_i` has no effect until UV_ARM_CYCLES ticks have been counted since the run began.
- R7: Once armed, `uv_i` high while running sets `fault_o` on the next edge, with `force_ls_o` left 0. While `fault_o` is 1, `ilim_code_o` and `pg_o` are 0.
- R8: `ov_i` high while `en_i` is high and no fault is latched sets both `fault_o` and `force_ls_o` on the next edge, at any point of the startup. When `ov_i` and an armed `uv_i` arrive together, the latch records overvoltage.
- R9: `hot_i` high drives `ilim_code_o` and `pg_o` to 0 without latching, and restarts all timers from zero.
- R10: `peer_fault_i` high drives `ilim_code_o` and `pg_o` to 0 and restarts all timers from zero.
- R11: A latched fault holds while `en_i` stays high; re-enabling after a drop restarts the ramp from code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Channel enable; low clears the fault latch |
| tick_i | input | 1 | One-cycle pulse per switching period |
| ov_i | input | 1 | Output above the overvoltage threshold |
| pg_low_i | input | 1 | Output below the power-good threshold |
| uv_i | input | 1 | Output below the deep undervoltage threshold |
| hot_i | input | 1 | Thermal shutdown flag, already hysteretic |
| peer_fault_i | input | 1 | Fault latch of the other channel |
| ilim_code_o | output | CODE_W | Current-limit code, 0 to RAMP_STEPS |
| pg_o | output | 1 | Power-good |
| fault_o | output | 1 | Fault latch |
| force_ls_o | output | 1 | Request to hold the low-side switch on |

## Verification
The bench thins the tick stream so that a design counting clocks instead of ticks would ramp too fast. It walks the code through every step and past the full-scale count, where a missing saturation would wrap to zero. Undervoltage is held asserted from before arming, so a design armed early would latch too soon. Overvoltage and undervoltage are fired together, where the wrong priority would leave the low-side request clear. Thermal and peer stops are lifted mid-ramp, so a design that paused its timers instead of restarting them would resume at a nonzero code.

// File: rtl/sup_pkg.sv
package sup_pkg;
  typedef enum logic [1:0] {
    TRIP_NONE = 2'd0,
    TRIP_OV   = 2'd1,
    TRIP_UV   = 2'd2
  } trip_e;
endpackage

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int LIMIT = 6144,
  localparam int W = $clog2(LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic adv_i,
  output logic done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (clr_i)                      cnt_q <= '0;
    else if (adv_i && !done_o)           cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == W'(LIMIT));
endmodule

// File: rtl/ilim_ramp.sv
module ilim_ramp #(
  parameter int RAMP_CYCLES = 512,
  parameter int RAMP_STEPS  = 5,
  localparam int STEP_LEN   = RAMP_CYCLES / RAMP_STEPS,
  localparam int SW         = $clog2(STEP_LEN + 1),
  localparam int CW         = $clog2(RAMP_STEPS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          adv_i,
  output logic [CW-1:0] code_o
);
  logic [SW-1:0] sub_q;
  logic [CW-1:0] idx_q;
  logic          full;

  assign full = (idx_q == CW'(RAMP_STEPS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sub_q <= '0;
      idx_q <= '0;
    end else if (clr_i) begin
      sub_q <= '0;
      idx_q <= '0;
    end else if (adv_i && !full) begin
      if (sub_q == SW'(STEP_LEN - 1)) begin
        sub_q <= '0;
        idx_q <= idx_q + 1'b1;
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end

  assign code_o = idx_q;
endmodule

// File: rtl/trip_latch.sv
module trip_latch
  import sup_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic run_i,
  input  logic armed_i,
  input  logic ov_i,
  input  logic uv_i,
  output logic fault_o,
  output logic force_ls_o
);
  trip_e trip_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              trip_q <= TRIP_NONE;
    else if (!en_i)                           trip_q <= TRIP_NONE;
    else if (trip_q == TRIP_NONE) begin
      // overvoltage wins over a simultaneous undervoltage
      if (ov_i)                               trip_q <= TRIP_OV;
      else if (run_i && armed_i && uv_i)      trip_q <= TRIP_UV;
    end
  end

  assign fault_o    = (trip_q != TRIP_NONE);
  assign force_ls_o = (trip_q == TRIP_OV);
endmodule

// File: rtl/chan_start_supervisor.sv
module chan_start_supervisor #(
  parameter int RAMP_CYCLES   = 512,
  parameter int RAMP_STEPS    = 5,
  parameter int PG_CYCLES     = 32768,
  parameter int UV_ARM_CYCLES = 6144,
  localparam int CODE_W       = $clog2(RAMP_STEPS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic              ov_i,
  input  logic              pg_low_i,
  input  logic              uv_i,
  input  logic              hot_i,
  input  logic              peer_fault_i,
  output logic [CODE_W-1:0] ilim_code_o,
  output logic              pg_o,
  output logic              fault_o,
  output logic              force_ls_o
);
  logic              run, clr, adv;
  logic              pg_done, uv_armed;
  logic [CODE_W-1:0] ramp_code;

  assign run = en_i & ~fault_o & ~peer_fault_i & ~hot_i;
  assign clr = ~run;
  assign adv = run & tick_i;

  ilim_ramp #(.RAMP_CYCLES(RAMP_CYCLES), .RAMP_STEPS(RAMP_STEPS)) u_ramp (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .adv_i(adv), .code_o(ramp_code)
  );

  tick_timer #(.LIMIT(PG_CYCLES)) u_pg_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .adv_i(adv), .done_o(pg_done)
  );

  tick_timer #(.LIMIT(UV_ARM_CYCLES)) u_uv_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .adv_i(adv), .done_o(uv_armed)
  );

  trip_latch u_trip (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .run_i(run), .armed_i(uv_armed),
    .ov_i(ov_i), .uv_i(uv_i), .fault_o(fault_o), .force_ls_o(force_ls_o)
  );

  assign ilim_code_o = run ? ramp_code : '0;
  assign pg_o        = run & pg_done & ~pg_low_i;
endmodule

// File: rtl/sup_checker.sv
module sup_checker #(
  parameter int RAMP_STEPS = 5,
  parameter int CODE_W     = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              pg_low_i,
  input logic              hot_i,
  input logic              peer_fault_i,
  input logic [CODE_W-1:0] ilim_code_o,
  input logic              pg_o,
  input logic              fault_o,
  input logic              force_ls_o
);
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (ilim_code_o == '0) && !pg_o);
  p_idle_clear_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !fault_o && !force_ls_o);
  p_single_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ilim_code_o > $past(ilim_code_o)) |-> (ilim_code_o == $past(ilim_code_o) + 1'b1));
  p_code_cap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ilim_code_o <= CODE_W'(RAMP_STEPS));
  p_pg_drop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pg_low_i |-> !pg_o);
  p_fault_stop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (ilim_code_o == '0) && !pg_o);
  p_force_implies_fault_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_ls_o |-> fault_o);
  p_hot_stop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hot_i |-> (ilim_code_o == '0) && !pg_o);
  p_peer_stop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    peer_fault_i |-> (ilim_code_o == '0) && !pg_o);
  p_latch_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && en_i) |=> fault_o);
endmodule

bind chan_start_supervisor sup_checker #(.RAMP_STEPS(RAMP_STEPS), .CODE_W(CODE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .pg_low_i(pg_low_i), .hot_i(hot_i),
  .peer_fault_i(peer_fault_i), .ilim_code_o(ilim_code_o), .pg_o(pg_o),
  .fault_o(fault_o), .force_ls_o(force_ls_o)
);

// File: tb/sim_chan_start_supervisor.sv
module sim_chan_start_supervisor;
  localparam int RC = 40, RS = 5, PG = 120, UVA = 60;
  localparam int STEP = RC / RS;
  localparam int CW = $clog2(RS + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 0, tick = 0, ov = 0, pgl = 0, uv = 0, hot = 0, peer = 0;
  logic [CW-1:0] code;
  logic pg, flt, fls;

  int checks = 0, fails = 0;
  string req = "R1";
  // reference model state
  int n = 0;
  bit m_flt = 0, m_ov = 0;

  always #10 clk = ~clk;

  chan_start_supervisor #(.RAMP_CYCLES(RC), .RAMP_STEPS(RS), .PG_CYCLES(PG),
                          .UV_ARM_CYCLES(UVA)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .tick_i(tick), .ov_i(ov),
    .pg_low_i(pgl), .uv_i(uv), .hot_i(hot), .peer_fault_i(peer),
    .ilim_code_o(code), .pg_o(pg), .fault_o(flt), .force_ls_o(fls)
  );

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // one clock per iteration; tick on every tdiv-th cycle
  task automatic cycles(int k, int tdiv);
    for (int i = 0; i < k; i++) begin
      bit run;
      int ec;
      @(negedge clk);
      tick = (i % tdiv == 0);
      #1;
      run = en && !m_flt && !peer && !hot;
      ec = (n / STEP > RS) ? RS : n / STEP;
      chk("ilim_code", code, run ? ec : 0);
      chk("pg", pg, (run && n >= PG && !pgl) ? 1 : 0);
      chk("fault", flt, m_flt);
      chk("force_ls", fls, m_ov);
      @(posedge clk);
      if (!en) begin
        m_flt = 0; m_ov = 0; n = 0;
      end else begin
        if (!m_flt && ov) begin m_flt = 1; m_ov = 1; end
        else if (!m_flt && run && n >= UVA && uv) m_flt = 1;
        if (!run) n = 0;
        else if (tick && n < 100000) n++;
      end
      #1;
    end
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #35 rst_n = 1'b1;
    req = "R1"; cycles(5, 1);
    // full ramp with tick every cycle, past saturation and pg
    en = 1;
    req = "R2"; cycles(STEP * RS - 1, 1);
    req = "R3"; cycles(20, 1);
    req = "R4"; cycles(PG, 1);
    req = "R5"; pgl = 1; cycles(3, 1); pgl = 0; cycles(3, 1);
    // re-enable with thinned ticks
    en = 0; req = "R11"; cycles(2, 1);
    en = 1; req = "R2"; cycles(STEP * 3 * 3, 3);
    // undervoltage before and after arming
    en = 0; cycles(2, 1); en = 1;
    uv = 1; req = "R6"; cycles(UVA - 1, 1);
    req = "R7"; cycles(6, 1);
    req = "R11"; cycles(10, 1);
    uv = 0; en = 0; req = "R1"; cycles(3, 1);
    // overvoltage during ramp, with armed uv priority
    en = 1; req = "R8"; cycles(12, 1); ov = 1; cycles(3, 1); ov = 0; cycles(4, 1);
    en = 0; cycles(2, 1); en = 1; cycles(UVA + 2, 1);
    ov = 1; uv = 1; cycles(3, 1); ov = 0; uv = 0;
    en = 0; cycles(2, 1); en = 1;
    // thermal and peer stops mid-ramp
    req = "R9"; cycles(20, 1); hot = 1; cycles(4, 1); hot = 0; cycles(15, 1);
    req = "R10"; peer = 1; cycles(4, 1); peer = 0; cycles(STEP * RS + 5, 2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule